// File: doc/BRIEF.md
# Multicycle 18-bit Load/Store Processor Core

This block is a compact processor core with an 18-bit word, sixteen general registers and a control unit built as a hardwired finite state machine. Each instruction walks through its own short sequence of states: a shared fetch and decode pair, then an execute, address, memory or control-flow step, and a final write or PC update. The instruction set has sixteen fixed opcodes. There are four register-register ALU forms and four register-immediate forms of AND, OR, ADD and XOR. Loads and stores use a base register plus a signed offset. There is one absolute jump and five signed conditional branches.

The program is written into a 256-word instruction store through a load port while the core is held in reset. After the reset is released, the core runs on its own from address zero. Data lives in a 1024-word read-write store that is cleared by reset. The current program counter and the controller state are brought out for observation. The asynchronous active-low reset is released to the core through a two-flop synchroniser.

Top module: `proc18_core`

## Requirements
- R1: While reset is held, and in the first cycle after it takes effect, dbg_pc is 0 and dbg_state is 0. All sixteen registers and every data word start at 0.
- R2: Bits 17:14 hold the opcode: AND=0, OR=1, ADD=2, XOR=3, ANDI=4, ORI=5, ADDI=6, XORI=7, LD=8, ST=9, JUMP=10, BEQ=11, BGT=12, BLT=13, BGE=14, BLE=15. The state that follows DECODE is chosen by this field alone.
- R3: Opcodes 0 to 3 write reg[13:10] := reg[9:6] op reg[5:2], with ADD modulo 2^18. The state sequence is 0,1,2,3 (FETCH, DECODE, EXECUTE, WRITEBACK).
- R4: Opcodes 4 to 7 use the sign-extended 6-bit field 5:0 as the second operand in place of reg[5:2]. The state sequence is also 0,1,2,3.
- R5: LD writes reg[13:10] := data[(reg[9:6] + sext(5:0))[9:0]]. The state sequence is 0,1,4,5,3.
- R6: ST writes data[(reg[9:6] + sext(5:0))[9:0]] := reg[13:10]. The state sequence is 0,1,4,6.
- R7: A branch compares reg[13:10] against reg[9:6] as signed values (BEQ equal, BGT greater, BLT less, BGE greater-or-equal, BLE less-or-equal). The next PC is PC+1+sext(5:0) when the condition holds and PC+1 otherwise. The state sequence is 0,1,7.
- R8: JUMP loads the PC with bits 13:0, zero-extended. The state sequence is 0,1,7.
- R9: Every other instruction continues at PC+1. dbg_pc holds one value through all the states of an instruction and changes only on entry to FETCH.
- R10: A fetch at a PC of 256 or more returns the all-zero word, which executes as AND r0,r0,r0.
- R11: Load-port writes have no effect while the core is out of reset.
- R12: Only bits 9:0 of a computed data address select the word, so addresses that differ only above bit 9 reach the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| prog_we | input | 1 | Instruction-store write strobe, accepted only while the core is in reset |
| prog_addr | input | 8 | Instruction-store word address for a load-port write |
| prog_data | input | 18 | Instruction word for a load-port write |
| dbg_pc | output | 18 | Program counter of the instruction in progress |
| dbg_state | output | 3 | Controller state code (0 FETCH, 1 DECODE, 2 EXECUTE, 3 WRITEBACK, 4 ADDR, 5 MEMREAD, 6 MEMWRITE, 7 FLOW) |

## Verification
The controller registers its state, so dbg_state moves one step per clock edge. A new PC appears together with state 0 on the edge that ends the instruction: four edges after FETCH for ALU forms and stores, five for loads and three for jumps and branches. The bench aligns once on the first DECODE after reset. From there it advances a reference model one instruction at a time and samples every cycle on the falling edge, comparing the state code against that instruction's sequence and the PC against the model's value. Register and memory contents are judged through the branch outcomes they later cause in randomly generated and hand-written programs.

// File: rtl/proc18_pkg.sv
package proc18_pkg;

  localparam int XLEN = 18;
  localparam int OPW  = 4;
  localparam int RIDX = 4;
  localparam int NREG = 1 << RIDX;
  localparam int IMMW = 6;
  localparam int JTW  = 14;
  localparam int STW  = 3;

  // Field positions inside an instruction word
  localparam int OP_LSB = XLEN - OPW;        // 14
  localparam int FA_LSB = OP_LSB - RIDX;     // 10, rd / ra
  localparam int FB_LSB = FA_LSB - RIDX;     // 6,  rs / rb
  localparam int FC_LSB = FB_LSB - RIDX;     // 2,  rt

  typedef enum logic [OPW-1:0] {
    OP_AND  = 4'd0,  OP_OR   = 4'd1,  OP_ADD  = 4'd2,  OP_XOR  = 4'd3,
    OP_ANDI = 4'd4,  OP_ORI  = 4'd5,  OP_ADDI = 4'd6,  OP_XORI = 4'd7,
    OP_LD   = 4'd8,  OP_ST   = 4'd9,  OP_JUMP = 4'd10, OP_BEQ  = 4'd11,
    OP_BGT  = 4'd12, OP_BLT  = 4'd13, OP_BGE  = 4'd14, OP_BLE  = 4'd15
  } opcode_e;

  typedef enum logic [STW-1:0] {
    ST_FETCH = 3'd0, ST_DECODE = 3'd1, ST_EXEC  = 3'd2, ST_WB   = 3'd3,
    ST_ADDR  = 3'd4, ST_MEMRD  = 3'd5, ST_MEMWR = 3'd6, ST_FLOW = 3'd7
  } state_e;

  typedef enum logic [1:0] {ALU_AND, ALU_OR, ALU_ADD, ALU_XOR} aluop_e;
  typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_JMP} pcsel_e;

  typedef struct packed {
    logic   ir_ld;
    logic   ops_ld;
    logic   res_ld;
    logic   mdr_ld;
    logic   rf_we;
    logic   wb_mem;
    logic   dm_we;
    logic   pc_we;
    logic   srcb_imm;
    aluop_e alu_op;
  } ctrl_t;

  function automatic logic op_is_reg(opcode_e op);
    return op[3:2] == 2'b00;
  endfunction

  function automatic logic op_is_imm(opcode_e op);
    return op[3:2] == 2'b01;
  endfunction

endpackage

// File: rtl/proc18_mem.sv
module proc18_mem #(
  parameter int W              = 18,
  parameter int DEPTH          = 256,
  parameter int AW             = 8,
  parameter bit CLEAR_ON_RESET = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam logic [AW:0] LIM = DEPTH[AW:0];

  logic [W-1:0] mem [DEPTH];
  logic         w_ok;

  assign w_ok  = ({1'b0, waddr} < LIM);
  assign rdata = ({1'b0, raddr} < LIM) ? mem[raddr] : '0;

  generate
    if (CLEAR_ON_RESET) begin : g_clear
      // Working store: zeroed by reset, written in normal operation.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && w_ok) begin
          mem[waddr] <= wdata;
        end
      end
    end else begin : g_load
      // Program store: keeps contents over reset, written only during it.
      always_ff @(posedge clk) begin
        if (we && !rst_n && w_ok) begin
          mem[waddr] <= wdata;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/proc18_regfile.sv
module proc18_regfile #(
  parameter int W  = 18,
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr1,
  input  logic [IW-1:0] raddr2,
  output logic [W-1:0]  rdata1,
  output logic [W-1:0]  rdata2
);

  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (we && (waddr == IW'(i))) regs[i] <= wdata;
      end
    end
  end

  assign rdata1 = regs[raddr1];
  assign rdata2 = regs[raddr2];

endmodule

// File: rtl/proc18_alu.sv
module proc18_alu
  import proc18_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluop_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y,
  output logic         eq,
  output logic         lt
);

  always_comb begin
    unique case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_ADD: y = a + b;
      ALU_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end

  assign eq = (a == b);
  assign lt = ($signed(a) < $signed(b));

endmodule

// File: rtl/proc18_ctrl.sv
module proc18_ctrl
  import proc18_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  opcode_e opcode,
  input  logic    flag_eq,
  input  logic    flag_lt,
  output state_e  state,
  output ctrl_t   ctl,
  output pcsel_e  pc_sel
);

  state_e state_q, state_d;
  logic   taken;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        if (op_is_reg(opcode) || op_is_imm(opcode)) state_d = ST_EXEC;
        else if (opcode == OP_LD || opcode == OP_ST) state_d = ST_ADDR;
        else                                         state_d = ST_FLOW;
      end
      ST_EXEC:   state_d = ST_WB;
      ST_ADDR:   state_d = (opcode == OP_LD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  state_d = ST_WB;
      ST_WB, ST_MEMWR, ST_FLOW: state_d = ST_FETCH;
      default:   state_d = ST_FETCH;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  // Signed branch condition
  always_comb begin
    unique case (opcode)
      OP_BEQ:  taken = flag_eq;
      OP_BGT:  taken = !flag_lt && !flag_eq;
      OP_BLT:  taken = flag_lt;
      OP_BGE:  taken = !flag_lt;
      OP_BLE:  taken = flag_lt || flag_eq;
      default: taken = 1'b0;
    endcase
  end

  // Per-state control outputs
  always_comb begin
    ctl          = '0;
    ctl.alu_op   = aluop_e'(opcode[1:0]);
    ctl.srcb_imm = op_is_imm(opcode);
    pc_sel       = PC_SEQ;
    unique case (state_q)
      ST_FETCH:  ctl.ir_ld  = 1'b1;
      ST_DECODE: ctl.ops_ld = 1'b1;
      ST_EXEC:   ctl.res_ld = 1'b1;
      ST_ADDR: begin
        ctl.res_ld   = 1'b1;
        ctl.alu_op   = ALU_ADD;
        ctl.srcb_imm = 1'b1;
      end
      ST_MEMRD:  ctl.mdr_ld = 1'b1;
      ST_WB: begin
        ctl.rf_we  = 1'b1;
        ctl.wb_mem = (opcode == OP_LD);
        ctl.pc_we  = 1'b1;
      end
      ST_MEMWR: begin
        ctl.dm_we = 1'b1;
        ctl.pc_we = 1'b1;
      end
      ST_FLOW: begin
        ctl.srcb_imm = 1'b0;
        ctl.pc_we    = 1'b1;
        if (opcode == OP_JUMP) pc_sel = PC_JMP;
        else if (taken)        pc_sel = PC_BR;
      end
      default: ;
    endcase
  end

  assign state = state_q;

  // R9: every instruction goes through DECODE right after FETCH
  p_decode_after_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FETCH |=> state_q == ST_DECODE);

  // R7: a control-flow instruction ends after its third state
  p_flow_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_FLOW |=> state_q == ST_FETCH);

  // R5: a load passes through MEMREAD only after ADDR
  p_memrd_after_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_MEMRD |-> $past(state_q) == ST_ADDR);

endmodule

// File: rtl/proc18_core.sv
module proc18_core
  import proc18_pkg::*;
#(
  parameter int IMEM_DEPTH = 256,
  parameter int DMEM_AW    = 10,
  localparam int IAW       = $clog2(IMEM_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [IAW-1:0]  prog_addr,
  input  logic [XLEN-1:0] prog_data,
  output logic [XLEN-1:0] dbg_pc,
  output logic [STW-1:0]  dbg_state
);

  localparam int DMEM_DEPTH = 1 << DMEM_AW;

  // Reset: asserted at once, released after two clock edges
  logic rst_s1_q, core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q   <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      rst_s1_q   <= 1'b1;
      core_rst_n <= rst_s1_q;
    end
  end

  // Datapath registers
  logic [XLEN-1:0] pc_q, ir_q, a_q, b_q, res_q, mdr_q;
  logic [XLEN-1:0] pc_d;

  // Control
  state_e  state;
  ctrl_t   ctl;
  pcsel_e  pc_sel;
  opcode_e opcode;

  // Datapath nets
  logic [XLEN-1:0] imem_rd, imem_word;
  logic [XLEN-1:0] rf_rd1, rf_rd2, rf_wdata;
  logic [XLEN-1:0] imm_sext, srcb, alu_y, dm_rdata;
  logic [RIDX-1:0] ra1, ra2;
  logic            flag_eq, flag_lt, pc_in_imem, is_flow_cmp;

  assign opcode     = opcode_e'(ir_q[XLEN-1:OP_LSB]);
  assign imm_sext   = {{(XLEN-IMMW){ir_q[IMMW-1]}}, ir_q[IMMW-1:0]};
  assign is_flow_cmp = (opcode >= OP_BEQ);

  // Instruction store: PC beyond its range fetches the zero word
  proc18_mem #(
    .W(XLEN), .DEPTH(IMEM_DEPTH), .AW(IAW), .CLEAR_ON_RESET(1'b0)
  ) u_imem (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (prog_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc_q[IAW-1:0]),
    .rdata (imem_rd)
  );

  assign pc_in_imem = (pc_q[XLEN-1:IAW] == '0);
  assign imem_word  = pc_in_imem ? imem_rd : '0;

  // Register-file read selects: branches read ra/rb, stores read rd as data
  always_comb begin
    if (is_flow_cmp) begin
      ra1 = ir_q[FA_LSB +: RIDX];
      ra2 = ir_q[FB_LSB +: RIDX];
    end else begin
      ra1 = ir_q[FB_LSB +: RIDX];
      ra2 = op_is_reg(opcode) ? ir_q[FC_LSB +: RIDX] : ir_q[FA_LSB +: RIDX];
    end
  end

  assign rf_wdata = ctl.wb_mem ? mdr_q : res_q;

  proc18_regfile #(.W(XLEN), .N(NREG), .IW(RIDX)) u_rf (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .we     (ctl.rf_we),
    .waddr  (ir_q[FA_LSB +: RIDX]),
    .wdata  (rf_wdata),
    .raddr1 (ra1),
    .raddr2 (ra2),
    .rdata1 (rf_rd1),
    .rdata2 (rf_rd2)
  );

  assign srcb = ctl.srcb_imm ? imm_sext : b_q;

  proc18_alu #(.W(XLEN)) u_alu (
    .op (ctl.alu_op),
    .a  (a_q),
    .b  (srcb),
    .y  (alu_y),
    .eq (flag_eq),
    .lt (flag_lt)
  );

  // Data store: only the low address bits select a word
  proc18_mem #(
    .W(XLEN), .DEPTH(DMEM_DEPTH), .AW(DMEM_AW), .CLEAR_ON_RESET(1'b1)
  ) u_dmem (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (ctl.dm_we),
    .waddr (res_q[DMEM_AW-1:0]),
    .wdata (b_q),
    .raddr (res_q[DMEM_AW-1:0]),
    .rdata (dm_rdata)
  );

  proc18_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .opcode  (opcode),
    .flag_eq (flag_eq),
    .flag_lt (flag_lt),
    .state   (state),
    .ctl     (ctl),
    .pc_sel  (pc_sel)
  );

  // Next PC
  always_comb begin
    unique case (pc_sel)
      PC_BR:   pc_d = pc_q + XLEN'(1) + imm_sext;
      PC_JMP:  pc_d = {{(XLEN-JTW){1'b0}}, ir_q[JTW-1:0]};
      default: pc_d = pc_q + XLEN'(1);
    endcase
  end

  // Datapath registers with explicit load enables
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
      mdr_q <= '0;
    end else begin
      if (ctl.pc_we)  pc_q  <= pc_d;
      if (ctl.ir_ld)  ir_q  <= imem_word;
      if (ctl.ops_ld) begin
        a_q <= rf_rd1;
        b_q <= rf_rd2;
      end
      if (ctl.res_ld) res_q <= alu_y;
      if (ctl.mdr_ld) mdr_q <= dm_rdata;
    end
  end

  assign dbg_pc    = pc_q;
  assign dbg_state = state;

  // R9: the PC moves only on the edge that closes an instruction
  p_pc_moves_at_end_r9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$stable(pc_q) |-> ($past(state) inside {ST_WB, ST_MEMWR, ST_FLOW}));

  // R7: an equal BEQ pair lands at PC+1+offset
  p_beq_taken_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == ST_FLOW && opcode == OP_BEQ && a_q == b_q)
    |=> pc_q == $past(pc_q) + XLEN'(1) + $past(imm_sext));

  // R7: a BLT whose signed condition fails falls through
  p_blt_not_taken_r7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == ST_FLOW && opcode == OP_BLT && !($signed(a_q) < $signed(b_q)))
    |=> pc_q == $past(pc_q) + XLEN'(1));

  // R8: the jump target is the zero-extended low field
  p_jump_target_r8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == ST_FLOW && opcode == OP_JUMP)
    |=> pc_q == {{(XLEN-JTW){1'b0}}, $past(ir_q[JTW-1:0])});

  // R5: a load writes back the word the data store returned a cycle earlier
  p_load_data_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (state == ST_WB && opcode == OP_LD) |-> rf_wdata == $past(dm_rdata));

  // R6: the data store is written only by a store in MEMWRITE
  p_store_only_r6: assert property (@(posedge clk) disable iff (!core_rst_n)
    ctl.dm_we |-> (opcode == OP_ST && state == ST_MEMWR));

endmodule

// File: tb/proc18_core_tb.sv
`timescale 1ns/1ps
module proc18_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we;
  logic [7:0]  prog_addr;
  logic [17:0] prog_data;
  logic [17:0] dbg_pc;
  logic [2:0]  dbg_state;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;   // 50 MHz

  proc18_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_we),
    .prog_addr (prog_addr),
    .prog_data (prog_data),
    .dbg_pc    (dbg_pc),
    .dbg_state (dbg_state)
  );

  // Reference machine state
  logic [17:0] m_im [256];
  logic [17:0] m_rf [16];
  logic [17:0] m_dm [1024];
  logic [17:0] m_pc;
  logic [31:0] seed;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic next_rand(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  // R2 encodings: opcode in 17:14
  function automatic logic [17:0] enc_r(int op, int rd, int rs, int rt);
    return {op[3:0], rd[3:0], rs[3:0], rt[3:0], 2'b00};
  endfunction
  function automatic logic [17:0] enc_i(int op, int rd, int rs, int imm);
    return {op[3:0], rd[3:0], rs[3:0], imm[5:0]};
  endfunction
  function automatic logic [17:0] enc_j(int tgt);
    return {4'd10, tgt[13:0]};
  endfunction

  function automatic logic [17:0] fetch_w(logic [17:0] pc);
    return (pc < 18'd256) ? m_im[pc[7:0]] : 18'd0;   // R10
  endfunction

  function automatic int n_states(logic [3:0] op);
    if (op < 4'd8)  return 4;
    if (op == 4'd8) return 5;
    if (op == 4'd9) return 4;
    return 3;
  endfunction

  function automatic int st_at(logic [3:0] op, int k);
    if (k == 0) return 0;
    if (k == 1) return 1;
    if (op < 4'd8)  return (k == 2) ? 2 : 3;
    if (op == 4'd8) return (k == 2) ? 4 : ((k == 3) ? 5 : 3);
    if (op == 4'd9) return (k == 2) ? 4 : 6;
    return 7;
  endfunction

  function automatic string cls_tag(logic [3:0] op);
    if (op < 4'd4)   return "R3";
    if (op < 4'd8)   return "R4";
    if (op == 4'd8)  return "R5";
    if (op == 4'd9)  return "R6";
    if (op == 4'd10) return "R8";
    return "R7";
  endfunction

  function automatic logic [17:0] alu_f(logic [1:0] f, logic [17:0] a, logic [17:0] b);
    case (f)
      2'd0:    return a & b;
      2'd1:    return a | b;
      2'd2:    return a + b;
      default: return a ^ b;
    endcase
  endfunction

  // Advance the reference by one instruction; returns tag for the next PC check
  task automatic model_step(input logic [17:0] w, output string ptag);
    logic [3:0]  op, fa, fb, fc;
    logic [17:0] imm, addr, va, vb;
    logic        tk;
    op  = w[17:14]; fa = w[13:10]; fb = w[9:6]; fc = w[5:2];
    imm = {{12{w[5]}}, w[5:0]};
    ptag = "R9";
    tk = 1'b0;
    addr = m_rf[fb] + imm;
    if (op < 4'd4) begin
      m_rf[fa] = alu_f(op[1:0], m_rf[fb], m_rf[fc]);
      m_pc = m_pc + 18'd1;
    end else if (op < 4'd8) begin
      m_rf[fa] = alu_f(op[1:0], m_rf[fb], imm);
      m_pc = m_pc + 18'd1;
    end else if (op == 4'd8) begin
      m_rf[fa] = m_dm[addr[9:0]];
      m_pc = m_pc + 18'd1;
      if (addr[17:10] != 0) ptag = "R12";
    end else if (op == 4'd9) begin
      m_dm[addr[9:0]] = m_rf[fa];
      m_pc = m_pc + 18'd1;
      if (addr[17:10] != 0) ptag = "R12";
    end else if (op == 4'd10) begin
      m_pc = {4'd0, w[13:0]};
      ptag = "R8";
    end else begin
      va = m_rf[fa]; vb = m_rf[fb];
      case (op)
        4'd11:   tk = (va == vb);
        4'd12:   tk = ($signed(va) > $signed(vb));
        4'd13:   tk = ($signed(va) < $signed(vb));
        4'd14:   tk = ($signed(va) >= $signed(vb));
        default: tk = ($signed(va) <= $signed(vb));
      endcase
      m_pc = tk ? (m_pc + 18'd1 + imm) : (m_pc + 18'd1);
      ptag = "R7";
    end
    if (m_pc >= 18'd256) ptag = "R10";
  endtask

  // Load m_im, reset, run n instructions comparing PC and state every cycle
  task automatic run_prog(input int n_instr, input bit tamper);
    logic [17:0] w;
    string       ptag, stag;
    bit          first;
    int          guard;
    rst_n = 1'b0;
    prog_we = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      prog_we   = 1'b1;
      prog_addr = i[7:0];
      prog_data = m_im[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    chk("R1", "pc in reset", int'(dbg_pc), 0);
    chk("R1", "state in reset", int'(dbg_state), 0);
    m_pc = '0;
    for (int i = 0; i < 16; i++)   m_rf[i] = '0;
    for (int i = 0; i < 1024; i++) m_dm[i] = '0;
    rst_n = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (dbg_state != 3'd1 && guard < 10);
    chk("R1", "first decode seen", int'(dbg_state), 1);
    chk("R1", "first pc", int'(dbg_pc), 0);
    if (tamper) begin
      prog_we   = 1'b1;                 // R11: must not land
      prog_addr = 8'd20;
      prog_data = enc_j(20);
    end
    first = 1'b1;
    ptag  = "R9";
    for (int n = 0; n < n_instr; n++) begin
      w = fetch_w(m_pc);
      for (int k = (n == 0) ? 1 : 0; k < n_states(w[17:14]); k++) begin
        if (!first) @(negedge clk);
        first = 1'b0;
        stag = (k == 2) ? "R2" : cls_tag(w[17:14]);
        chk(stag, "state", int'(dbg_state), st_at(w[17:14], k));
        if (k == 0) chk(tamper ? "R11" : ptag, "pc", int'(dbg_pc), int'(m_pc));
      end
      model_step(w, ptag);
    end
    prog_we = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; prog_we = 1'b0; prog_addr = '0; prog_data = '0;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);

    // Hand-written program: signed compares, aliasing, out-of-range fetch
    for (int i = 0; i < 256; i++) m_im[i] = '0;
    m_im[0]  = enc_i(6, 1, 0, -1);    // r1 = -1
    m_im[1]  = enc_i(6, 2, 0, 5);     // r2 = 5
    m_im[2]  = enc_r(2, 3, 1, 2);     // r3 = 4 (wraps)
    m_im[3]  = enc_i(9, 3, 1, 0);     // ST to 0x3FFFF -> word 0x3FF (R12)
    m_im[4]  = enc_i(8, 4, 1, 0);     // LD back
    m_im[5]  = enc_i(11, 4, 3, 1);    // BEQ taken
    m_im[6]  = enc_j(6);
    m_im[7]  = enc_i(13, 1, 2, 1);    // BLT -1<5 taken
    m_im[8]  = enc_j(8);
    m_im[9]  = enc_i(12, 1, 2, 2);    // BGT not taken
    m_im[10] = enc_i(14, 2, 2, 1);    // BGE equal taken
    m_im[11] = enc_j(11);
    m_im[12] = enc_i(15, 1, 0, 1);    // BLE taken
    m_im[13] = enc_j(13);
    m_im[14] = enc_r(3, 5, 1, 2);
    m_im[15] = enc_r(1, 6, 2, 3);
    m_im[16] = enc_r(0, 7, 1, 2);
    m_im[17] = enc_i(7, 8, 2, -3);
    m_im[18] = enc_i(5, 9, 2, 8);
    m_im[19] = enc_i(4, 10, 1, -4);
    m_im[20] = enc_i(8, 11, 0, 20);   // cleared data word (R1)
    m_im[21] = enc_i(11, 11, 0, 2);   // BEQ taken only if zero
    m_im[22] = enc_j(22);
    m_im[23] = enc_j(23);
    m_im[24] = enc_i(11, 1, 2, -30);  // not taken
    m_im[25] = enc_j(300);            // beyond store (R10)
    run_prog(40, 1'b1);

    // Pseudo-random programs over the whole opcode space
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 256; i++) begin
        next_rand(r);
        if (r[3:0] == 4'd10) m_im[i] = enc_j(int'(r[15:8]));
        else                 m_im[i] = {r[3:0], r[21:8]};
      end
      run_prog(400, 1'b0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule